// File: doc/BRIEF.md
# Credit-Gated DRAM Channel Arbiter

Several second-level cache slices share one DRAM channel, and each slice presents the head of its outbound request queue. Each cycle this block chooses at most one slice in rotating order and pops that slice's head. The popped request goes into a short delay queue, where it carries a due time equal to the issue cycle plus a fixed channel latency. When the oldest entry in that queue is due and the channel can accept its direction, the entry is pushed into the channel.

Admission is limited by credits. Every slice owns one private credit, and all slices draw on one shared pool. The pool is sized from the depths of the channel's scheduler and return queues, minus one for each slice beyond the first, plus the write queue depth when the channel keeps writes in a separate queue. The slice that issues always spends its private credit before it takes anything from the pool. When the channel releases a request, a credit return names the source slice, and the shared credit comes back before the private one. The channel reports read-full and write-full separately. Both the arbiter and the delay queue check the flag that matches the direction of the request in hand.

Top module: `subpart_dram_arbiter`

## Requirements
- R1: While reset is asserted, no pop strobe and no channel push is raised, whatever the slice heads present.
- R2: At most one pop strobe is high in any cycle.
- R3: The scan starts at the slice that follows the last one that issued and wraps modulo the slice count. After reset the scan starts at slice 0.
- R4: A slice is a candidate only when its head is valid and it has credit. It has credit when its private credit is unused or the shared pool has a free credit. The first candidate in scan order is popped unless R5 or R9 blocks it.
- R5: If the channel is full for the direction of the first candidate (write flag 1 selects write-full, 0 selects read-full), nothing is popped that cycle, and later candidates are not considered.
- R6: An issue spends the slice's private credit when it is unused, and otherwise one shared credit. Shared credits in use never exceed scheduler depth + return depth − (slices − 1), plus the write queue depth when the separate-write option is set.
- R7: A popped request is pushed to the channel exactly the fixed latency later when the channel is not full. In general it is pushed in the first cycle at or after its due time in which the channel is not full for its direction.
- R8: While the oldest due entry is blocked by the full flag for its direction, no push occurs and the presented push fields hold steady. Entries leave in issue order.
- R9: No pop occurs while the delay queue holds its parameterised depth of entries.
- R10: A credit return for a slice releases one shared credit held by that slice if it holds any, and otherwise its private credit. A return for a slice that holds nothing has no effect.
- R11: A push carries the write flag and tag of the popped head, together with the index of the source slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_valid | input | N_SUB | Per-slice head present |
| hd_write | input | N_SUB | Per-slice head is a write |
| hd_tag | input | N_SUB*TAG_W | Per-slice head tag, slice s at bits s*TAG_W upward |
| dram_rd_full | input | 1 | Channel cannot take a read |
| dram_wr_full | input | 1 | Channel cannot take a write |
| crd_ret_valid | input | 1 | Channel released a request |
| crd_ret_id | input | ID_W | Slice whose credit returns |
| hd_pop | output | N_SUB | Pop strobe per slice |
| dram_push_valid | output | 1 | Push into channel this cycle |
| dram_push_write | output | 1 | Pushed request is a write |
| dram_push_tag | output | TAG_W | Pushed request tag |
| dram_push_src | output | ID_W | Source slice of pushed request |

## Verification
The bound checker tests a set of rules on every cycle. It confirms that reset is silent, that no more than one pop is raised, and that a pop never goes to an absent head. It checks that nothing issues or pushes against the full flag for the request's direction, that the shared pool stays within its cap, that nothing pops while the delay queue is full, and that a blocked head keeps its fields. The properties cannot tell which slice should have won, what latency was actually applied, or what order credits came back in. Only the bench's reference model can show those: the rotation sequence, the stop on a blocked first candidate, the exact latency, the total issue count allowed by private plus shared credits, and a return that arrives for a slice holding nothing.

// File: rtl/sda_pkg.sv
package sda_pkg;

  localparam int STAMP_W = 16;
  typedef logic [STAMP_W-1:0] stamp_t;

  // Shared credit cap derived from channel queue depths.
  function automatic int calc_shared_limit(int sched_q, int ret_q, int n_sub,
                                           int wr_q, bit sep_wr);
    int lim;
    lim = sched_q + ret_q - (n_sub - 1);
    if (sep_wr) lim = lim + wr_q;
    if (lim < 1) lim = 1;
    return lim;
  endfunction

  // Wrap-safe "now is at or past due".
  function automatic logic stamp_reached(stamp_t now, stamp_t due);
    stamp_t diff;
    diff = now - due;
    return ~diff[STAMP_W-1];
  endfunction

  // Slice visited at scan offset off, starting after last.
  function automatic int rr_slot(int last, int off, int n);
    return (last + 1 + off) % n;
  endfunction

endpackage

// File: rtl/sda_rr_picker.sv
module sda_rr_picker #(
  parameter int N    = 4,
  parameter int ID_W = 2
) (
  input  logic [ID_W-1:0] last_id,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    cred_ok,
  input  logic [N-1:0]    req_write,
  input  logic            rd_full,
  input  logic            wr_full,
  input  logic            slot_full,
  input  logic            en,
  output logic [N-1:0]    grant,
  output logic [ID_W-1:0] grant_id,
  output logic            grant_any,
  output logic            stalled
);
  import sda_pkg::*;

  always_comb begin
    logic found;
    int   idx;
    found     = 1'b0;
    idx       = 0;
    grant     = '0;
    grant_id  = '0;
    grant_any = 1'b0;
    stalled   = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = rr_slot(int'(last_id), i, N);
      if (!found && req_valid[idx] && cred_ok[idx]) begin
        found = 1'b1;
        if (en && !(req_write[idx] ? wr_full : rd_full) && !slot_full) begin
          grant[idx] = 1'b1;
          grant_id   = ID_W'(idx);
          grant_any  = 1'b1;
        end else begin
          stalled = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sda_credit_ledger.sv
module sda_credit_ledger #(
  parameter int N    = 4,
  parameter int ID_W = 2,
  parameter int LIM  = 3,
  parameter int SH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [ID_W-1:0] take_id,
  input  logic            ret_valid,
  input  logic [ID_W-1:0] ret_id,
  output logic [N-1:0]    cred_ok,
  output logic [SH_W-1:0] shared_used,
  output logic            took_shared,
  output logic            rel_shared,
  output logic            rel_private
);

  logic [N-1:0]    priv_q;
  logic [SH_W-1:0] held_q [N];
  logic [SH_W-1:0] used_q;

  assign shared_used = used_q;
  assign took_shared = take && priv_q[take_id];
  assign rel_shared  = ret_valid && (held_q[ret_id] != '0);
  assign rel_private = ret_valid && !rel_shared && priv_q[ret_id];

  for (genvar s = 0; s < N; s++) begin : g_ok
    assign cred_ok[s] = !priv_q[s] || (used_q < SH_W'(LIM));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= '0;
      used_q <= '0;
      for (int s = 0; s < N; s++) held_q[s] <= '0;
    end else begin
      for (int s = 0; s < N; s++) begin
        if (take && take_id == ID_W'(s) && !took_shared) priv_q[s] <= 1'b1;
        else if (rel_private && ret_id == ID_W'(s))      priv_q[s] <= 1'b0;
        held_q[s] <= held_q[s]
                   + SH_W'(take && took_shared && take_id == ID_W'(s))
                   - SH_W'(rel_shared && ret_id == ID_W'(s));
      end
      used_q <= used_q + SH_W'(took_shared) - SH_W'(rel_shared);
    end
  end

endmodule

// File: rtl/sda_delay_fifo.sv
module sda_delay_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign rd_data = mem_q[rptr_q];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wptr_q <= bump(wptr_q);
      if (rd_en) rptr_q <= bump(rptr_q);
      cnt_q <= cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

endmodule

// File: rtl/subpart_dram_arbiter.sv
module subpart_dram_arbiter #(
  parameter int N_SUB         = 4,
  parameter int TAG_W         = 8,
  parameter int DRAM_LAT      = 4,
  parameter int DFIFO_DEPTH   = 4,
  parameter int SCHED_Q_DEPTH = 8,
  parameter int RET_Q_DEPTH   = 4,
  parameter int WR_Q_DEPTH    = 4,
  parameter bit SEP_WR_Q      = 1'b1,
  localparam int ID_W         = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SUB-1:0]       hd_valid,
  input  logic [N_SUB-1:0]       hd_write,
  input  logic [N_SUB*TAG_W-1:0] hd_tag,
  input  logic                   dram_rd_full,
  input  logic                   dram_wr_full,
  input  logic                   crd_ret_valid,
  input  logic [ID_W-1:0]        crd_ret_id,
  output logic [N_SUB-1:0]       hd_pop,
  output logic                   dram_push_valid,
  output logic                   dram_push_write,
  output logic [TAG_W-1:0]       dram_push_tag,
  output logic [ID_W-1:0]        dram_push_src
);
  import sda_pkg::*;

  localparam int SHARED_LIM = calc_shared_limit(SCHED_Q_DEPTH, RET_Q_DEPTH,
                                                N_SUB, WR_Q_DEPTH, SEP_WR_Q);
  localparam int SH_W = $clog2(SHARED_LIM + 1);

  typedef struct packed {
    stamp_t            due;
    logic              wr;
    logic [TAG_W-1:0]  tag;
    logic [ID_W-1:0]   src;
  } entry_t;
  localparam int ENT_W = $bits(entry_t);

  // Named internal events
  stamp_t            now_q;
  logic [ID_W-1:0]   last_q;
  logic [N_SUB-1:0]  cred_ok;
  logic [SH_W-1:0]   shared_used;
  logic              took_shared, rel_shared, rel_private;
  logic [ID_W-1:0]   grant_id;
  logic              grant_any, scan_stalled;
  logic              fifo_full, fifo_empty;
  entry_t            ent_in, head;
  logic [ENT_W-1:0]  head_raw;
  logic              head_due, head_blocked;

  sda_rr_picker #(.N(N_SUB), .ID_W(ID_W)) u_pick (
    .last_id   (last_q),
    .req_valid (hd_valid),
    .cred_ok   (cred_ok),
    .req_write (hd_write),
    .rd_full   (dram_rd_full),
    .wr_full   (dram_wr_full),
    .slot_full (fifo_full),
    .en        (rst_n),
    .grant     (hd_pop),
    .grant_id  (grant_id),
    .grant_any (grant_any),
    .stalled   (scan_stalled)
  );

  sda_credit_ledger #(.N(N_SUB), .ID_W(ID_W), .LIM(SHARED_LIM), .SH_W(SH_W)) u_cred (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (grant_any),
    .take_id     (grant_id),
    .ret_valid   (crd_ret_valid),
    .ret_id      (crd_ret_id),
    .cred_ok     (cred_ok),
    .shared_used (shared_used),
    .took_shared (took_shared),
    .rel_shared  (rel_shared),
    .rel_private (rel_private)
  );

  always_comb begin
    ent_in.due = now_q + stamp_t'(DRAM_LAT);
    ent_in.wr  = hd_write[grant_id];
    ent_in.tag = hd_tag[int'(grant_id)*TAG_W +: TAG_W];
    ent_in.src = grant_id;
  end

  sda_delay_fifo #(.DEPTH(DFIFO_DEPTH), .W(ENT_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (grant_any),
    .wr_data (ent_in),
    .rd_en   (dram_push_valid),
    .rd_data (head_raw),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  assign head            = entry_t'(head_raw);
  assign head_due        = !fifo_empty && stamp_reached(now_q, head.due);
  assign head_blocked    = head.wr ? dram_wr_full : dram_rd_full;
  assign dram_push_valid = head_due && !head_blocked;
  assign dram_push_write = head.wr;
  assign dram_push_tag   = head.tag;
  assign dram_push_src   = head.src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q  <= '0;
      last_q <= ID_W'(N_SUB - 1);
    end else begin
      now_q <= now_q + 1'b1;
      if (grant_any) last_q <= grant_id;
    end
  end

endmodule

// File: rtl/sda_arb_checker.sv
module sda_arb_checker #(
  parameter int N     = 4,
  parameter int ID_W  = 2,
  parameter int TAG_W = 8,
  parameter int SH_W  = 2,
  parameter int LIM   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    hd_valid,
  input logic [N-1:0]    hd_write,
  input logic [N-1:0]    hd_pop,
  input logic            dram_rd_full,
  input logic            dram_wr_full,
  input logic            dram_push_valid,
  input logic            dram_push_write,
  input logic [TAG_W-1:0] dram_push_tag,
  input logic [ID_W-1:0] dram_push_src,
  input logic            fifo_full,
  input logic            fifo_empty,
  input logic [SH_W-1:0] shared_used
);

  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (hd_pop == '0 && !dram_push_valid));

  p_single_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hd_pop));

  p_pop_needs_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_pop & ~hd_valid) == '0);

  p_no_write_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hd_pop & hd_write)) |-> !dram_wr_full);

  p_no_read_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hd_pop & ~hd_write)) |-> !dram_rd_full);

  p_shared_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shared_used <= SH_W'(LIM));

  p_push_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dram_push_valid |-> !(dram_push_write ? dram_wr_full : dram_rd_full));

  p_head_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && !dram_push_valid) |=>
      $stable({dram_push_write, dram_push_tag, dram_push_src}));

  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> hd_pop == '0);

endmodule

bind subpart_dram_arbiter sda_arb_checker #(
  .N(N_SUB), .ID_W(ID_W), .TAG_W(TAG_W), .SH_W(SH_W), .LIM(SHARED_LIM)
) u_chk (.*);

// File: tb/subpart_dram_arbiter_tb.sv
module subpart_dram_arbiter_tb;

  localparam int N = 4, TW = 8, LAT = 5, FD = 2;
  localparam int SQ = 2, RQ = 3, WQ = 1, SEP = 1;
  localparam int LIM = (SEP != 0) ? (SQ + RQ + WQ + 1 - N) : (SQ + RQ + 1 - N);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic [N-1:0]   hd_valid, hd_write, hd_pop;
  logic [N*TW-1:0] hd_tag;
  logic           dram_rd_full, dram_wr_full, crd_ret_valid;
  logic [1:0]     crd_ret_id, dram_push_src;
  logic           dram_push_valid, dram_push_write;
  logic [TW-1:0]  dram_push_tag;

  subpart_dram_arbiter #(
    .N_SUB(N), .TAG_W(TW), .DRAM_LAT(LAT), .DFIFO_DEPTH(FD),
    .SCHED_Q_DEPTH(SQ), .RET_Q_DEPTH(RQ), .WR_Q_DEPTH(WQ), .SEP_WR_Q(1'b1)
  ) u_dut (.*);

  typedef struct { bit wr; bit [7:0] tag; } item_t;
  typedef struct { int due; bit wr; bit [7:0] tag; int src; } rent_t;

  item_t subq [N][$];
  rent_t rf [$];
  int    retq [$];
  int    glog [$];
  int    priv [N];
  int    shr [N];
  int    sh_used, last_g, t;
  bit    rdf, wrf, ret_en, bogus_v;
  int    bogus_id;
  int    n_chk, n_fail;
  string cur_req;
  int    pop_seen, push_seen, last_pop_t, last_push_t, last_push_tag;
  bit [7:0] next_tag;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_item(int s, bit wr);
    item_t it;
    it.wr = wr;
    it.tag = next_tag;
    next_tag++;
    subq[s].push_back(it);
  endtask

  task automatic step();
    int g, rid, gi;
    bit found, epush, rv, ts, rs, rp, bl;
    logic [N-1:0] epop;
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      hd_valid[s] = subq[s].size() > 0;
      hd_write[s] = (subq[s].size() > 0) ? subq[s][0].wr : 1'b0;
      hd_tag[s*TW +: TW] = (subq[s].size() > 0) ? subq[s][0].tag : 8'h00;
    end
    dram_rd_full = rdf;
    dram_wr_full = wrf;
    rv = 0; rid = 0;
    if (bogus_v) begin rv = 1; rid = bogus_id; end
    else if (ret_en && retq.size() > 0) begin rv = 1; rid = retq[0]; end
    crd_ret_valid = rv;
    crd_ret_id = 2'(rid);
    #1;
    g = -1; found = 0;
    for (int k = 0; k < N; k++) begin
      int s;
      s = (last_g + 1 + k) % N;
      if (!found && subq[s].size() > 0 && (priv[s] == 0 || sh_used < LIM)) begin
        found = 1;
        bl = subq[s][0].wr ? wrf : rdf;
        if (!bl && rf.size() < FD) g = s;
      end
    end
    epop = '0;
    if (g >= 0) epop[g] = 1'b1;
    epush = rf.size() > 0 && t >= rf[0].due && !(rf[0].wr ? wrf : rdf);
    chk($countones(hd_pop) <= 1, "R2", "pop count", $countones(hd_pop), 1);
    chk(hd_pop == epop, {"R4 ", cur_req}, "pop vector", int'(hd_pop), int'(epop));
    chk(dram_push_valid == epush, {"R7 ", cur_req}, "push valid",
        int'(dram_push_valid), int'(epush));
    if (epush && dram_push_valid) begin
      chk(dram_push_tag == rf[0].tag, "R11", "push tag", int'(dram_push_tag), int'(rf[0].tag));
      chk(dram_push_write == rf[0].wr, "R11", "push write", int'(dram_push_write), int'(rf[0].wr));
      chk(int'(dram_push_src) == rf[0].src, "R11", "push src", int'(dram_push_src), rf[0].src);
    end
    if (|hd_pop) begin
      gi = 0;
      for (int s = 0; s < N; s++) if (hd_pop[s]) gi = s;
      pop_seen++;
      glog.push_back(gi);
      last_pop_t = t;
    end
    if (dram_push_valid) begin
      push_seen++;
      last_push_t = t;
      last_push_tag = int'(dram_push_tag);
    end
    ts = (g >= 0) && priv[g] == 1;
    rs = rv && shr[rid] > 0;
    rp = rv && !rs && priv[rid] == 1;
    if (epush) begin
      retq.push_back(rf[0].src);
      void'(rf.pop_front());
    end
    if (g >= 0) begin
      rent_t e;
      e.due = t + LAT; e.wr = subq[g][0].wr; e.tag = subq[g][0].tag; e.src = g;
      rf.push_back(e);
      void'(subq[g].pop_front());
      last_g = g;
      if (ts) begin shr[g]++; sh_used++; end
      else priv[g] = 1;
    end
    if (rs) begin shr[rid]--; sh_used--; end
    if (rp) priv[rid] = 0;
    if (rv && !bogus_v) void'(retq.pop_front());
    t++;
  endtask

  function automatic bit all_idle();
    bit idle;
    idle = rf.size() == 0 && retq.size() == 0 && sh_used == 0;
    for (int s = 0; s < N; s++) if (subq[s].size() > 0 || priv[s] != 0) idle = 0;
    return idle;
  endfunction

  task automatic drain();
    ret_en = 1; rdf = 0; wrf = 0;
    for (int i = 0; i < 400; i++) begin
      step();
      if (all_idle()) break;
    end
    chk(all_idle(), "R10", "credits settled", 0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int start;
    n_chk = 0; n_fail = 0; next_tag = 8'h10;
    sh_used = 0; last_g = N - 1; t = 0;
    rdf = 0; wrf = 0; ret_en = 1; bogus_v = 0; bogus_id = 0;
    for (int s = 0; s < N; s++) begin priv[s] = 0; shr[s] = 0; end
    cur_req = "R1";
    rst_n = 0; hd_valid = '1; hd_write = '0; hd_tag = '0;
    dram_rd_full = 0; dram_wr_full = 0; crd_ret_valid = 0; crd_ret_id = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(hd_pop == '0 && !dram_push_valid, "R1", "quiet in reset",
          int'(hd_pop), 0);
    end
    @(negedge clk);
    hd_valid = '0;
    rst_n = 1;

    // R7 / R11: single read latency and payload
    cur_req = "R7";
    add_item(0, 0);
    for (int i = 0; i < 10; i++) step();
    chk(last_push_t - last_pop_t == LAT, "R7", "pop-to-push cycles",
        last_push_t - last_pop_t, LAT);
    chk(last_push_tag == 8'h10, "R11", "pushed tag", last_push_tag, 8'h10);
    drain();

    // R3: rotation order
    cur_req = "R3";
    start = (last_g + 1) % N;
    for (int s = 0; s < N; s++) begin add_item(s, 0); add_item(s, 1); end
    glog.delete();
    for (int i = 0; i < 60 && glog.size() < 4; i++) step();
    for (int k = 0; k < 4; k++)
      chk(k < glog.size() && glog[k] == (start + k) % N, "R3", "grant order",
          (k < glog.size()) ? glog[k] : -1, (start + k) % N);
    drain();

    // R9: delay queue depth caps early issue
    cur_req = "R9";
    for (int s = 0; s < N; s++) begin add_item(s, 0); add_item(s, 0); end
    pop_seen = 0;
    for (int i = 0; i < LAT; i++) step();
    chk(pop_seen == FD, "R9", "pops before first due", pop_seen, FD);
    drain();

    // R5: blocked first candidate halts the scan
    cur_req = "R5";
    start = (last_g + 1) % N;
    add_item(start, 0);
    add_item((start + 1) % N, 1);
    rdf = 1;
    pop_seen = 0;
    for (int i = 0; i < 6; i++) step();
    chk(pop_seen == 0, "R5", "pops while first read blocked", pop_seen, 0);
    drain();

    // R8: due head held by write-full
    cur_req = "R8";
    add_item((last_g + 1) % N, 1);
    pop_seen = 0;
    for (int i = 0; i < 4 && pop_seen == 0; i++) step();
    wrf = 1;
    push_seen = 0;
    for (int i = 0; i < LAT + 4; i++) step();
    chk(push_seen == 0, "R8", "pushes while write-full", push_seen, 0);
    wrf = 0;
    push_seen = 0;
    for (int i = 0; i < 3; i++) step();
    chk(push_seen == 1, "R8", "push after release", push_seen, 1);
    drain();

    // R10: return for a slice holding nothing
    cur_req = "R10";
    bogus_v = 1; bogus_id = 2;
    step();
    bogus_v = 0;

    // R6: private then shared, no returns
    cur_req = "R6";
    ret_en = 0;
    for (int s = 0; s < N; s++) for (int j = 0; j < 4; j++) add_item(s, j[0]);
    pop_seen = 0;
    for (int i = 0; i < 60; i++) step();
    chk(pop_seen == N + LIM, "R6", "issues with credits exhausted", pop_seen, N + LIM);
    chk(pop_seen == N + LIM, "R10", "stray return granted nothing", pop_seen, N + LIM);
    drain();

    // Mixed traffic with random backpressure and returns
    cur_req = "R10";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) add_item($urandom_range(0, N - 1), 1'($urandom_range(0, 1)));
      rdf = ($urandom_range(0, 4) == 0);
      wrf = ($urandom_range(0, 4) == 0);
      ret_en = ($urandom_range(0, 3) != 0);
      step();
    end
    drain();

    summary();
    $finish;
  end

endmodule